// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns one PWM reference into a complementary pair of drive signals, a high-side output and a low-side output. At every change of the reference, the output that is about to switch off does so on the next clock edge. The output that is about to switch on waits for a programmed dead time first, so the two are never active together. The dead time is given as an 8-bit code that expands into a piecewise-linear count of dead-time base ticks. A single-cycle tick-enable input marks each base tick.

A main enable input and an idle-hold select govern what happens when the outputs are switched off. With idle-hold set, dropping the main enable first forces both outputs inactive. After the dead time, they take the two programmed idle levels, and the block keeps driving them. With idle-hold clear, the outputs are released: both read inactive and the output-enable to the pad logic goes low. When the main enable returns, a dead time is inserted before either output goes active. All outputs are active high.

Top module: `pwm_deadtime_pair`

## Requirements
- R1: After reset, with the main enable low, the block is already in its settled idle state. With idle-hold set it drives the idle levels and holds the output-enable at 1. With idle-hold clear, all three outputs are 0.
- R2: A code with bit 7 at 0 gives a dead time equal to the code value in ticks (0 to 127).
- R3: A code whose bits 7:6 are 10 gives a dead time of (64 + bits 5:0) x 2 ticks.
- R4: A code whose bits 7:5 are 110 gives a dead time of (32 + bits 4:0) x 8 ticks.
- R5: A code whose bits 7:5 are 111 gives a dead time of (32 + bits 4:0) x 16 ticks.
- R6: When the reference changes while the main enable is high, the output going inactive drops on the first clock edge that samples the change. The output going active rises on the clock edge that consumes the last of the dead-time ticks counted after that edge.
- R7: While the main enable is high, the two outputs are never both 1.
- R8: If the reference changes back before the dead time has run out, the output that was waiting never goes active for that pulse.
- R9: A code of 0 gives no delay: the output going active switches on the same edge the other output drops.
- R10: The dead-time count advances only in cycles where the tick-enable is 1. With tick-enable held at 0, a pending output stays inactive.
- R11: When the main enable falls with idle-hold at 1, both outputs go to 0 at once and take their idle levels after the dead time. The output-enable stays 1 throughout.
- R12: While the main enable is low with idle-hold at 0, the output-enable and both outputs are 0, and changes of the reference have no effect.
- R13: When the main enable rises, both outputs stay inactive for the dead time. After that they follow the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Dead-time base tick, one cycle wide |
| ref_in | input | 1 | PWM reference |
| dt_code | input | 8 | Dead-time code |
| main_en | input | 1 | Main output enable |
| idle_hold | input | 1 | 1: keep driving idle levels when disabled; 0: release |
| idle_oc | input | 1 | Idle level of the high-side output |
| idle_ocn | input | 1 | Idle level of the low-side output |
| out_oc | output | 1 | High-side output |
| out_ocn | output | 1 | Low-side output |
| out_oe | output | 1 | Output enable toward the pad logic |

## Verification
The bench builds the block with the default counter width of 10 bits. This width holds the longest dead time, 1008 ticks, so the largest code in each of the four decode ranges can be measured end to end. For the range checks, the tick-enable is held high, so each measured latency in cycles equals the dead time in ticks. The gating of the count is checked separately, with sparse tick pulses.

// File: rtl/pwm_deadtime_pair.sv
module pwm_deadtime_pair #(
  parameter int CNT_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       ref_in,
  input  logic [7:0] dt_code,
  input  logic       main_en,
  input  logic       idle_hold,
  input  logic       idle_oc,
  input  logic       idle_ocn,
  output logic       out_oc,
  output logic       out_ocn,
  output logic       out_oe
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] decode_dt(input logic [7:0] c);
    logic [CNT_W-1:0] v;
    if (!c[7])      v = CNT_W'(c[6:0]);
    else if (!c[6]) v = CNT_W'({1'b1, c[5:0]}) << 1;
    else if (!c[5]) v = CNT_W'({1'b1, c[4:0]}) << 3;
    else            v = CNT_W'({1'b1, c[4:0]}) << 4;
    return v;
  endfunction

  logic             main_q;
  logic             ref_q;
  logic             done;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dt_now;

  assign dt_now = decode_dt(dt_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= 1'b0;
      ref_q  <= 1'b0;
      done   <= 1'b1;
      cnt    <= '0;
    end else if (main_en != main_q) begin
      main_q <= main_en;
      ref_q  <= ref_in;
      cnt    <= dt_now;
      done   <= (dt_now == '0);
    end else if (main_q && (ref_in != ref_q)) begin
      ref_q  <= ref_in;
      cnt    <= dt_now;
      done   <= (dt_now == '0);
    end else if (!done && tick_en) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) done <= 1'b1;
    end
  end

  assign out_oe  = main_q | idle_hold;
  assign out_oc  = main_q ? (ref_q & done)  : (idle_hold & done & idle_oc);
  assign out_ocn = main_q ? (~ref_q & done) : (idle_hold & done & idle_ocn);

endmodule

// File: rtl/pwm_deadtime_pair_chk.sv
module pwm_deadtime_pair_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             main_q,
  input logic             done,
  input logic [CNT_W-1:0] cnt,
  input logic [7:0]       dt_code,
  input logic             idle_hold,
  input logic             out_oc,
  input logic             out_ocn,
  input logic             out_oe
);

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    main_q |-> !(out_oc && out_ocn));

  a_r6_oc_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q && $past(main_q) && $rose(out_oc) && ($past(dt_code) != 8'h00))
      |-> !$past(out_ocn));

  a_r6_ocn_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q && $past(main_q) && $rose(out_ocn) && ($past(dt_code) != 8'h00))
      |-> !$past(out_oc));

  a_r11_idle_forced: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(main_q) && idle_hold && ($past(dt_code) != 8'h00))
      |-> (!out_oc && !out_ocn && out_oe));

  a_r12_released_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_oe |-> (!out_oc && !out_ocn));

  a_r10_pending_count: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (cnt != '0));

endmodule

bind pwm_deadtime_pair pwm_deadtime_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .main_q(main_q), .done(done), .cnt(cnt),
  .dt_code(dt_code), .idle_hold(idle_hold), .out_oc(out_oc),
  .out_ocn(out_ocn), .out_oe(out_oe)
);

// File: tb/pwm_deadtime_pair_bench.sv
module pwm_deadtime_pair_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 1'b1, ref_in = 1'b0, main_en = 1'b0;
  logic idle_hold = 1'b1, idle_oc = 1'b1, idle_ocn = 1'b0;
  logic [7:0] dt_code = 8'h00;
  logic out_oc, out_ocn, out_oe;
  int total = 0, bad = 0;
  bit overlap = 1'b0;

  always #10 clk = ~clk;

  pwm_deadtime_pair u_pwm_deadtime_pair (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ref_in(ref_in),
    .dt_code(dt_code), .main_en(main_en), .idle_hold(idle_hold),
    .idle_oc(idle_oc), .idle_ocn(idle_ocn), .out_oc(out_oc),
    .out_ocn(out_ocn), .out_oe(out_oe)
  );

  always @(negedge clk) if (rst_n && out_oc && out_ocn) overlap = 1'b1;

  function automatic int exp_dt(input int v);
    if (v < 128) return v;
    if (v < 192) return 2 * (v - 64);
    if (v < 224) return 8 * (v - 160);
    return 16 * (v - 192);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_high(input bit on_oc, output int n);
    n = 1;
    @(negedge clk);
    while (((on_oc ? out_oc : out_ocn) == 1'b0) && n < 1100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    chk(out_oe && out_oc && !out_ocn, "R1", {out_oe, out_oc, out_ocn}, 3'b110);
  endtask

  task automatic t_enable_zero;
    int n;
    dt_code = 8'h00; ref_in = 1'b0; main_en = 1'b1;
    @(negedge clk);
    chk(out_ocn && !out_oc, "R9", {out_oc, out_ocn}, 2'b01);
    ref_in = 1'b1;
    @(negedge clk);
    chk(out_oc && !out_ocn, "R9", {out_oc, out_ocn}, 2'b10);
    ref_in = 1'b0;
    wait_high(1'b0, n);
  endtask

  task automatic t_range(input logic [7:0] c, input string req);
    int n;
    int e;
    e = exp_dt(int'(c));
    dt_code = c; ref_in = 1'b1;
    @(negedge clk);
    chk(!out_ocn, "R6", out_ocn, 0);
    n = 1;
    while (!out_oc && n < 1100) begin
      @(negedge clk);
      n++;
    end
    chk(n - 1 == e, req, n - 1, e);
    ref_in = 1'b0;
    wait_high(1'b0, n);
  endtask

  task automatic t_fall;
    int n;
    dt_code = 8'd37; ref_in = 1'b1;
    wait_high(1'b1, n);
    ref_in = 1'b0;
    @(negedge clk);
    chk(!out_oc && !out_ocn, "R6", {out_oc, out_ocn}, 0);
    n = 1;
    while (!out_ocn && n < 1100) begin
      @(negedge clk);
      n++;
    end
    chk(n - 1 == 37, "R6", n - 1, 37);
  endtask

  task automatic t_short;
    int n;
    bit seen = 1'b0;
    dt_code = 8'd10; ref_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (out_oc) seen = 1'b1;
    end
    ref_in = 1'b0;
    n = 1;
    @(negedge clk);
    while (!out_ocn && n < 1100) begin
      if (out_oc) seen = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(!seen, "R8", seen, 0);
    chk(n - 1 == 10, "R8", n - 1, 10);
  endtask

  task automatic t_tick;
    int n;
    bit early = 1'b0;
    dt_code = 8'd4; tick_en = 1'b0; ref_in = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (out_oc) early = 1'b1;
    end
    chk(!early, "R10", early, 0);
    for (int p = 1; p <= 4; p++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      if (p < 4 && out_oc) early = 1'b1;
      if (p == 4) chk(out_oc, "R10", out_oc, 1);
      @(negedge clk);
      @(negedge clk);
    end
    chk(!early, "R10", early, 0);
    tick_en = 1'b1; ref_in = 1'b0;
    wait_high(1'b0, n);
  endtask

  task automatic t_idle;
    int n;
    dt_code = 8'd20; ref_in = 1'b1;
    wait_high(1'b1, n);
    idle_hold = 1'b1; idle_oc = 1'b0; idle_ocn = 1'b1; main_en = 1'b0;
    @(negedge clk);
    chk(!out_oc && !out_ocn && out_oe, "R11", {out_oe, out_oc, out_ocn}, 3'b100);
    n = 1;
    while (!out_ocn && n < 1100) begin
      @(negedge clk);
      n++;
    end
    chk(n - 1 == 20 && !out_oc && out_oe, "R11", n - 1, 20);
  endtask

  task automatic t_release;
    bit moved = 1'b0;
    idle_hold = 1'b0;
    for (int i = 0; i < 6; i++) begin
      ref_in = ~ref_in;
      @(negedge clk);
      if (out_oe || out_oc || out_ocn) moved = 1'b1;
    end
    chk(!moved, "R12", moved, 0);
  endtask

  task automatic t_reenable;
    int n;
    dt_code = 8'd20; ref_in = 1'b1; main_en = 1'b1;
    @(negedge clk);
    chk(out_oe && !out_oc && !out_ocn, "R13", {out_oe, out_oc, out_ocn}, 3'b100);
    n = 1;
    while (!out_oc && n < 1100) begin
      @(negedge clk);
      n++;
    end
    chk(n - 1 == 20, "R13", n - 1, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_zero();
    t_range(8'h05, "R2");
    t_range(8'h7F, "R2");
    t_range(8'h80, "R3");
    t_range(8'hBF, "R3");
    t_range(8'hC0, "R4");
    t_range(8'hDF, "R4");
    t_range(8'hE0, "R5");
    t_range(8'hFF, "R5");
    t_fall();
    t_short();
    t_tick();
    t_idle();
    t_release();
    t_reenable();
    chk(!overlap, "R7", overlap, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule